// File: doc/BRIEF.md
# Wavefront Initial Register State Sequencer

This block prepares the starting contents of the registers of a new wavefront. A one-cycle start pulse captures a dispatch-wide parameter set (a four-word scratch buffer descriptor, four 64-bit pointer or ID values, a scratch offset, a private size, grid and work-group sizes) together with the per-wave system values and the per-lane work-item IDs. It then drives a scalar write port, one 32-bit register per cycle, followed by a vector write port, one lane-wide register per cycle.

Ten user fields are each gated by one enable bit. Enabled fields take consecutive scalar register numbers from 0, and a disabled field takes no number at all. User content stops after sixteen registers. Five single-register system values come next, each with its own enable. After them come one, two or three work-item ID vector registers. Two kinds of value are computed inside the block: the per-dimension work-group counts, which are ceiling divisions, and the private size, which is rounded up to a whole number of 4-byte words.

Top module: `wave_init_seq`

## Requirements
- R1: A start pulse seen while idle captures every data input. Changes to the inputs, and any further start pulse, have no effect until done has been asserted.
- R2: User fields are emitted in this fixed order, with user_en_i bit n enabling field n: bit 0 scratch descriptor (4 words, bits [31:0] first); bit 1 dispatch pointer; bit 2 queue pointer; bit 3 kernarg pointer; bit 4 dispatch ID (each 2 words, low word first); bit 5 flat scratch (2 words); bit 6 private size (1); bits 7, 8, 9 work-group count X, Y, Z (1 each).
- R3: Scalar indices begin at 0 and go up by one on every write. Disabled fields take no index. Writes fall on consecutive cycles with no gaps.
- R4: No more than 16 user words are written, and any content past the 16th is dropped. user_cnt_o reports the enabled user word count, saturated at 16.
- R5: The work-group count for each dimension is ceil(grid / wg), computed without overflow.
- R6: A work-group size of zero produces a count of 32'hFFFFFFFF. err_o is high when any enabled count field has a zero divisor.
- R7: The private size word is priv_size_i rounded up to a multiple of 4. The flat scratch field is scratch_off_i followed by that rounded size.
- R8: System words come straight after the last user word. sys_en_i bits 0 to 4 enable, in order: work-group ID X, Y, Z, the info word, and the wave offset.
- R9: The info word is {first_wave_i, 14'b0, oa_term_i[10:0], wave_count_i[5:0]}.
- R10: Vector writes follow the scalar writes with indices 0, 1, 2 for IDs X, Y, Z. vid_mode_i 0 writes X only, 1 writes X and Y, 2 or 3 writes X, Y and Z.
- R11: The two write ports are never active together. done_o pulses one cycle after the last write, and busy_o is high from the cycle after start until that done cycle.
- R12: After reset no write is active and busy_o, done_o, err_o and user_cnt_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| user_en_i | input | 10 | User field enables |
| sys_en_i | input | 5 | System word enables |
| vid_mode_i | input | 2 | Work-item ID set selector |
| scratch_desc_i | input | 128 | Scratch buffer descriptor |
| dispatch_ptr_i | input | 64 | Dispatch packet address |
| queue_ptr_i | input | 64 | Queue object address |
| kernarg_ptr_i | input | 64 | Kernel argument address |
| dispatch_id_i | input | 64 | Dispatch identifier |
| scratch_off_i | input | 32 | Dispatch scratch byte offset |
| priv_size_i | input | 32 | Per-item private size in bytes |
| grid_size_i | input | 3x32 | Grid size, X in [0] |
| wg_size_i | input | 3x32 | Work-group size, X in [0] |
| wg_id_i | input | 3x32 | Work-group ID of this wave |
| first_wave_i | input | 1 | First-wave flag |
| oa_term_i | input | 11 | Ordered append term |
| wave_count_i | input | 6 | Group size in waves |
| wave_off_i | input | 32 | Wave scratch byte offset |
| item_id_i | input | 3xLANESx32 | Per-lane work-item IDs, X in [0] |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end pulse |
| err_o | output | 1 | Zero divisor in an enabled count |
| user_cnt_o | output | 5 | Saturated user word count |
| sgpr_we_o | output | 1 | Scalar write valid |
| sgpr_idx_o | output | 5 | Scalar register index |
| sgpr_data_o | output | 32 | Scalar write data |
| vgpr_we_o | output | 1 | Vector write valid |
| vgpr_idx_o | output | 2 | Vector register index |
| vgpr_data_o | output | LANESx32 | Vector write data, lane 0 lowest |

## Verification
The assertions assume only that reset is applied once before use. They place no limit on data values, enable patterns or the timing of start, so the stimulus drives start pulses while the block is busy and changes the inputs partway through a sequence. Mode 3 and zero divisors are fed in on purpose, because the block defines what both of them do. The stimulus keeps all inputs at known values, so the captured set is always defined.

// File: rtl/wis_pkg.sv
// Package: shared constants, phase encoding and captured parameter set.
// Assumes 32-bit scalar words; slot numbering fixes the emission order.
package wis_pkg;
    localparam int WORD_W      = 32;
    localparam int USER_FIELDS = 10;
    localparam int USER_SLOTS  = 18;
    localparam int SYS_SLOTS   = 5;
    localparam int ALL_SLOTS   = USER_SLOTS + SYS_SLOTS;
    localparam int USER_CAP    = 16;
    localparam int SLOT_W      = $clog2(ALL_SLOTS + 1);
    localparam int SIDX_W      = $clog2(USER_CAP + SYS_SLOTS);
    localparam int UCNT_W      = $clog2(USER_CAP + 1);

    typedef enum logic [1:0] {PH_IDLE, PH_SCALAR, PH_VECTOR, PH_FINISH} phase_t;

    typedef struct packed {
        logic [4*WORD_W-1:0]   desc;
        logic [2*WORD_W-1:0]   dptr;
        logic [2*WORD_W-1:0]   qptr;
        logic [2*WORD_W-1:0]   kptr;
        logic [2*WORD_W-1:0]   did;
        logic [WORD_W-1:0]     scr_off;
        logic [WORD_W-1:0]     psize;
        logic [2:0][WORD_W-1:0] wgid;
        logic                  first_wave;
        logic [10:0]           oa_term;
        logic [5:0]            wave_cnt;
        logic [WORD_W-1:0]     wave_off;
    } disp_t;

    // One bit per user word slot, copied from the enable of its field.
    function automatic logic [USER_SLOTS-1:0] expand_user(input logic [USER_FIELDS-1:0] en);
        return {en[9], en[8], en[7], en[6], {2{en[5]}}, {2{en[4]}},
                {2{en[3]}}, {2{en[2]}}, {2{en[1]}}, {4{en[0]}}};
    endfunction

    // Enabled user words, saturated at the cap.
    function automatic logic [UCNT_W-1:0] user_words(input logic [USER_FIELDS-1:0] en);
        int n;
        n = 4 * int'(en[0]) + 2 * (int'(en[1]) + int'(en[2]) + int'(en[3]) + int'(en[4]) + int'(en[5]))
          + int'(en[6]) + int'(en[7]) + int'(en[8]) + int'(en[9]);
        if (n > USER_CAP) n = USER_CAP;
        return UCNT_W'(n);
    endfunction
endpackage

// File: rtl/wis_ceil_div.sv
// Module: ceiling division of a grid extent by a work-group extent.
// Assumes unsigned operands; a zero divisor returns all ones and flags it.
module wis_ceil_div #(
    parameter int W = 32
) (
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] den_i,
    output logic [W-1:0] quo_o,
    output logic         div_zero_o
);
    logic [W:0] sum;

    // Widened numerator plus divisor minus one, then the guarded quotient.
    always_comb begin
        sum        = {1'b0, num_i} + {1'b0, den_i} - (W+1)'(1);
        div_zero_o = (den_i == '0);
        quo_o      = div_zero_o ? '1 : W'(sum / {1'b0, den_i});
    end
endmodule

// File: rtl/wis_slot_pick.sv
// Module: finds the lowest set bit of a candidate mask.
// Assumes N >= 2; found_o low means pos_o is don't-care (driven 0).
module wis_slot_pick #(
    parameter int N  = 23,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  mask_i,
    output logic          found_o,
    output logic [IW-1:0] pos_o
);
    // Scan from the top so the lowest set bit wins.
    always_comb begin
        found_o = 1'b0;
        pos_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask_i[i]) begin
                found_o = 1'b1;
                pos_o   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/wis_slot_data.sv
// Module: maps a scalar slot number onto its 32-bit data word.
// Assumes slot order: 0..17 user words, 18..22 system words.
module wis_slot_data
    import wis_pkg::*;
#(
    parameter int IW = 5
) (
    input  disp_t                  disp_i,
    input  logic [2:0][WORD_W-1:0] counts_i,
    input  logic [IW-1:0]          slot_i,
    output logic [WORD_W-1:0]      word_o
);
    logic [WORD_W-1:0] psize_rnd;
    logic [WORD_W-1:0] info;

    // Derived words: rounded private size and packed wave info.
    always_comb begin
        psize_rnd = (disp_i.psize + WORD_W'(3)) & ~WORD_W'(3);
        info      = {disp_i.first_wave, 14'b0, disp_i.oa_term, disp_i.wave_cnt};
    end

    // Slot to word selection.
    always_comb begin
        unique case (slot_i)
            IW'(0):  word_o = disp_i.desc[31:0];
            IW'(1):  word_o = disp_i.desc[63:32];
            IW'(2):  word_o = disp_i.desc[95:64];
            IW'(3):  word_o = disp_i.desc[127:96];
            IW'(4):  word_o = disp_i.dptr[31:0];
            IW'(5):  word_o = disp_i.dptr[63:32];
            IW'(6):  word_o = disp_i.qptr[31:0];
            IW'(7):  word_o = disp_i.qptr[63:32];
            IW'(8):  word_o = disp_i.kptr[31:0];
            IW'(9):  word_o = disp_i.kptr[63:32];
            IW'(10): word_o = disp_i.did[31:0];
            IW'(11): word_o = disp_i.did[63:32];
            IW'(12): word_o = disp_i.scr_off;
            IW'(13): word_o = psize_rnd;
            IW'(14): word_o = psize_rnd;
            IW'(15): word_o = counts_i[0];
            IW'(16): word_o = counts_i[1];
            IW'(17): word_o = counts_i[2];
            IW'(18): word_o = disp_i.wgid[0];
            IW'(19): word_o = disp_i.wgid[1];
            IW'(20): word_o = disp_i.wgid[2];
            IW'(21): word_o = info;
            IW'(22): word_o = disp_i.wave_off;
            default: word_o = '0;
        endcase
    end
endmodule

// File: rtl/wave_init_seq.sv
// Module: sequences the initial scalar and vector register writes of a wave.
// Assumes synchronous active-low reset; start is honoured only while idle.
// Emits one write per cycle: enabled user words (capped), system words, then IDs.
module wave_init_seq
    import wis_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start_i,
    input  logic [USER_FIELDS-1:0]            user_en_i,
    input  logic [SYS_SLOTS-1:0]              sys_en_i,
    input  logic [1:0]                        vid_mode_i,
    input  logic [4*WORD_W-1:0]               scratch_desc_i,
    input  logic [2*WORD_W-1:0]               dispatch_ptr_i,
    input  logic [2*WORD_W-1:0]               queue_ptr_i,
    input  logic [2*WORD_W-1:0]               kernarg_ptr_i,
    input  logic [2*WORD_W-1:0]               dispatch_id_i,
    input  logic [WORD_W-1:0]                 scratch_off_i,
    input  logic [WORD_W-1:0]                 priv_size_i,
    input  logic [2:0][WORD_W-1:0]            grid_size_i,
    input  logic [2:0][WORD_W-1:0]            wg_size_i,
    input  logic [2:0][WORD_W-1:0]            wg_id_i,
    input  logic                              first_wave_i,
    input  logic [10:0]                       oa_term_i,
    input  logic [5:0]                        wave_count_i,
    input  logic [WORD_W-1:0]                 wave_off_i,
    input  logic [2:0][LANES-1:0][WORD_W-1:0] item_id_i,
    output logic                              busy_o,
    output logic                              done_o,
    output logic                              err_o,
    output logic [UCNT_W-1:0]                 user_cnt_o,
    output logic                              sgpr_we_o,
    output logic [SIDX_W-1:0]                 sgpr_idx_o,
    output logic [WORD_W-1:0]                 sgpr_data_o,
    output logic                              vgpr_we_o,
    output logic [1:0]                        vgpr_idx_o,
    output logic [LANES*WORD_W-1:0]           vgpr_data_o
);
    localparam int PICK_W = $clog2(ALL_SLOTS);

    phase_t                             phase_q;
    logic [SLOT_W-1:0]                  sp_q;
    logic [UCNT_W-1:0]                  ucnt_q;
    logic [SIDX_W-1:0]                  scnt_q;
    logic [1:0]                         vcnt_q;
    disp_t                              disp_q;
    logic [USER_FIELDS-1:0]             user_en_q;
    logic [SYS_SLOTS-1:0]               sys_en_q;
    logic [1:0]                         vmode_q;
    logic [2:0][WORD_W-1:0]             grid_q;
    logic [2:0][WORD_W-1:0]             wgsz_q;
    logic [2:0][LANES-1:0][WORD_W-1:0]  item_q;

    logic [2:0][WORD_W-1:0]             counts;
    logic [2:0]                         div_zero;
    logic [ALL_SLOTS-1:0]               above;
    logic [USER_SLOTS-1:0]              user_live;
    logic [ALL_SLOTS-1:0]               cand;
    logic                               found;
    logic [PICK_W-1:0]                  pos;
    logic [WORD_W-1:0]                  slot_word;
    logic [1:0]                         last_v;
    logic [LANES*WORD_W-1:0]            vec_word;

    // One ceiling divider per grid dimension.
    for (genvar d = 0; d < 3; d++) begin : g_div
        wis_ceil_div #(.W(WORD_W)) u_div (
            .num_i      (grid_q[d]),
            .den_i      (wgsz_q[d]),
            .quo_o      (counts[d]),
            .div_zero_o (div_zero[d])
        );
    end

    // Candidate slots: enabled, not yet passed, user words only below the cap.
    always_comb begin
        for (int i = 0; i < ALL_SLOTS; i++) above[i] = (SLOT_W'(i) >= sp_q);
        user_live = (ucnt_q < UCNT_W'(USER_CAP)) ? expand_user(user_en_q) : '0;
        cand      = {sys_en_q, user_live} & above;
    end

    wis_slot_pick #(.N(ALL_SLOTS), .IW(PICK_W)) u_pick (
        .mask_i  (cand),
        .found_o (found),
        .pos_o   (pos)
    );

    wis_slot_data #(.IW(PICK_W)) u_data (
        .disp_i   (disp_q),
        .counts_i (counts),
        .slot_i   (pos),
        .word_o   (slot_word)
    );

    // Last vector index for the captured mode and the current vector word.
    always_comb begin
        unique case (vmode_q)
            2'd0:    last_v = 2'd0;
            2'd1:    last_v = 2'd1;
            default: last_v = 2'd2;
        endcase
        unique case (vcnt_q)
            2'd0:    vec_word = item_q[0];
            2'd1:    vec_word = item_q[1];
            default: vec_word = item_q[2];
        endcase
    end

    // Status from the captured set.
    assign err_o      = |(div_zero & user_en_q[9:7]);
    assign user_cnt_o = user_words(user_en_q);

    // Sequencer: capture, scalar walk, vector walk, finish pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= PH_IDLE;
            sp_q        <= '0;
            ucnt_q      <= '0;
            scnt_q      <= '0;
            vcnt_q      <= '0;
            disp_q      <= '0;
            user_en_q   <= '0;
            sys_en_q    <= '0;
            vmode_q     <= '0;
            grid_q      <= '0;
            wgsz_q      <= '0;
            item_q      <= '0;
            busy_o      <= 1'b0;
            done_o      <= 1'b0;
            sgpr_we_o   <= 1'b0;
            sgpr_idx_o  <= '0;
            sgpr_data_o <= '0;
            vgpr_we_o   <= 1'b0;
            vgpr_idx_o  <= '0;
            vgpr_data_o <= '0;
        end else begin
            sgpr_we_o <= 1'b0;
            vgpr_we_o <= 1'b0;
            done_o    <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        disp_q.desc       <= scratch_desc_i;
                        disp_q.dptr       <= dispatch_ptr_i;
                        disp_q.qptr       <= queue_ptr_i;
                        disp_q.kptr       <= kernarg_ptr_i;
                        disp_q.did        <= dispatch_id_i;
                        disp_q.scr_off    <= scratch_off_i;
                        disp_q.psize      <= priv_size_i;
                        disp_q.wgid       <= wg_id_i;
                        disp_q.first_wave <= first_wave_i;
                        disp_q.oa_term    <= oa_term_i;
                        disp_q.wave_cnt   <= wave_count_i;
                        disp_q.wave_off   <= wave_off_i;
                        user_en_q         <= user_en_i;
                        sys_en_q          <= sys_en_i;
                        vmode_q           <= vid_mode_i;
                        grid_q            <= grid_size_i;
                        wgsz_q            <= wg_size_i;
                        item_q            <= item_id_i;
                        sp_q              <= '0;
                        ucnt_q            <= '0;
                        scnt_q            <= '0;
                        vcnt_q            <= '0;
                        busy_o            <= 1'b1;
                        phase_q           <= PH_SCALAR;
                    end
                end
                PH_SCALAR: begin
                    if (found) begin
                        sgpr_we_o   <= 1'b1;
                        sgpr_idx_o  <= scnt_q;
                        sgpr_data_o <= slot_word;
                        scnt_q      <= scnt_q + 1'b1;
                        sp_q        <= SLOT_W'(pos) + 1'b1;
                        if (int'(pos) < USER_SLOTS) ucnt_q <= ucnt_q + 1'b1;
                    end else begin
                        vgpr_we_o   <= 1'b1;
                        vgpr_idx_o  <= 2'd0;
                        vgpr_data_o <= item_q[0];
                        vcnt_q      <= 2'd1;
                        phase_q     <= (last_v == 2'd0) ? PH_FINISH : PH_VECTOR;
                    end
                end
                PH_VECTOR: begin
                    vgpr_we_o   <= 1'b1;
                    vgpr_idx_o  <= vcnt_q;
                    vgpr_data_o <= vec_word;
                    vcnt_q      <= vcnt_q + 1'b1;
                    if (vcnt_q == last_v) phase_q <= PH_FINISH;
                end
                PH_FINISH: begin
                    done_o  <= 1'b1;
                    busy_o  <= 1'b0;
                    phase_q <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // The user word counter never passes the cap.
    assert_user_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ucnt_q <= UCNT_W'(USER_CAP));

    // Back-to-back scalar writes use consecutive indices.
    assert_dense_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sgpr_we_o && $past(sgpr_we_o)) |-> (sgpr_idx_o == $past(sgpr_idx_o) + 1'b1));

    // A scalar burst starts at index 0.
    assert_first_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sgpr_we_o && !$past(sgpr_we_o)) |-> (sgpr_idx_o == '0));

    // Vector writes begin at 0 and step by one.
    assert_vec_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
        vgpr_we_o |-> (vgpr_idx_o == ($past(vgpr_we_o) ? $past(vgpr_idx_o) + 2'd1 : 2'd0)));

    // Ports never write together.
    assert_port_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(sgpr_we_o && vgpr_we_o));

    // Done follows a write cycle directly.
    assert_done_after_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(vgpr_we_o));

    // Captured values stay put while a sequence runs.
    assert_capture_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_IDLE) |=> ($stable(user_en_q) && $stable(grid_q) && $stable(disp_q)));
endmodule

// File: tb/wave_init_seq_tb.sv
module wave_init_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 4;
    localparam int NVEC       = 7;
    localparam int VW         = 49;

    // {user_en[10], sys_en[5], vmode[2], grid_x[16], wg_x[16]}
    localparam logic [VW-1:0] TBL [NVEC] = '{
        {10'h3FF, 5'h1F, 2'd2, 16'd100, 16'd7},
        {10'h000, 5'h00, 2'd0, 16'd10,  16'd2},
        {10'h0A5, 5'h15, 2'd1, 16'd64,  16'd8},
        {10'h380, 5'h00, 2'd3, 16'd65,  16'd8},
        {10'h380, 5'h04, 2'd0, 16'd5,   16'd0},
        {10'h0FE, 5'h1F, 2'd1, 16'd1,   16'd1},
        {10'h001, 5'h08, 2'd2, 16'd3,   16'd4}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [9:0] user_en = '0;
    logic [4:0] sys_en = '0;
    logic [1:0] vmode = '0;
    logic [127:0] desc = '0;
    logic [63:0] dptr = '0, qptr = '0, kptr = '0, did = '0;
    logic [31:0] scr_off = '0, psize = '0, wave_off = '0;
    logic [2:0][31:0] grid = '0, wgsz = '0, wgid = '0;
    logic first_wave = 1'b0;
    logic [10:0] oa_term = '0;
    logic [5:0] wave_cnt = '0;
    logic [2:0][LANES-1:0][31:0] items = '0;

    logic busy, done, err, sgpr_we, vgpr_we;
    logic [4:0] user_cnt, sgpr_idx;
    logic [31:0] sgpr_data;
    logic [1:0] vgpr_idx;
    logic [LANES*32-1:0] vgpr_data;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [31:0] exp_s [0:31];
    logic [LANES*32-1:0] exp_v [0:3];
    int exp_ns, exp_nv, exp_ucnt;
    logic exp_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    wave_init_seq #(.LANES(LANES)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .user_en_i(user_en), .sys_en_i(sys_en),
        .vid_mode_i(vmode), .scratch_desc_i(desc), .dispatch_ptr_i(dptr), .queue_ptr_i(qptr),
        .kernarg_ptr_i(kptr), .dispatch_id_i(did), .scratch_off_i(scr_off), .priv_size_i(psize),
        .grid_size_i(grid), .wg_size_i(wgsz), .wg_id_i(wgid), .first_wave_i(first_wave),
        .oa_term_i(oa_term), .wave_count_i(wave_cnt), .wave_off_i(wave_off), .item_id_i(items),
        .busy_o(busy), .done_o(done), .err_o(err), .user_cnt_o(user_cnt),
        .sgpr_we_o(sgpr_we), .sgpr_idx_o(sgpr_idx), .sgpr_data_o(sgpr_data),
        .vgpr_we_o(vgpr_we), .vgpr_idx_o(vgpr_idx), .vgpr_data_o(vgpr_data)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    function automatic logic [31:0] ref_ceil(input logic [31:0] g, input logic [31:0] w);
        logic [63:0] s;
        if (w == 0) return 32'hFFFF_FFFF;
        s = ({32'b0, g} + {32'b0, w} - 64'd1) / {32'b0, w};
        return s[31:0];
    endfunction

    task automatic push_s(input logic [31:0] w, input bit is_user);
        if (!is_user || exp_ns < 16) begin
            exp_s[exp_ns] = w;
            exp_ns++;
        end
    endtask

    // Expected write list derived from the requirements (R2, R4, R5, R7, R8, R9, R10).
    task automatic build_expected();
        logic [31:0] rnd;
        rnd = ((psize + 32'd3) / 32'd4) * 32'd4;
        exp_ns = 0;
        if (user_en[0]) for (int k = 0; k < 4; k++) push_s(desc[k*32 +: 32], 1);
        if (user_en[1]) begin push_s(dptr[31:0], 1); push_s(dptr[63:32], 1); end
        if (user_en[2]) begin push_s(qptr[31:0], 1); push_s(qptr[63:32], 1); end
        if (user_en[3]) begin push_s(kptr[31:0], 1); push_s(kptr[63:32], 1); end
        if (user_en[4]) begin push_s(did[31:0], 1); push_s(did[63:32], 1); end
        if (user_en[5]) begin push_s(scr_off, 1); push_s(rnd, 1); end
        if (user_en[6]) push_s(rnd, 1);
        for (int d = 0; d < 3; d++) if (user_en[7+d]) push_s(ref_ceil(grid[d], wgsz[d]), 1);
        exp_ucnt = 4*user_en[0] + 2*(user_en[1]+user_en[2]+user_en[3]+user_en[4]+user_en[5])
                 + user_en[6] + user_en[7] + user_en[8] + user_en[9];
        if (exp_ucnt > 16) exp_ucnt = 16;
        for (int d = 0; d < 3; d++) if (sys_en[d]) push_s(wgid[d], 0);
        if (sys_en[3]) push_s({first_wave, 14'b0, oa_term, wave_cnt}, 0);
        if (sys_en[4]) push_s(wave_off, 0);
        exp_nv = (vmode == 2'd0) ? 1 : (vmode == 2'd1) ? 2 : 3;
        for (int d = 0; d < 3; d++) exp_v[d] = items[d];
        exp_err = 1'b0;
        for (int d = 0; d < 3; d++) if (user_en[7+d] && wgsz[d] == 0) exp_err = 1'b1;
    endtask

    task automatic set_inputs(input int t);
        logic [VW-1:0] e;
        e = TBL[t];
        user_en = e[48:39];
        sys_en  = e[38:34];
        vmode   = e[33:32];
        grid    = '{32'd1 + 32'(t), 32'(e[31:16]) + 32'd3, 32'(e[31:16])};
        wgsz    = '{32'd1, 32'd4, 32'(e[15:0])};
        for (int k = 0; k < 4; k++) desc[k*32 +: 32] = 32'hD000_0000 + 32'(t*16 + k);
        dptr    = {32'hA100_0000 + 32'(t), 32'hA000_0000 + 32'(t)};
        qptr    = {32'hB100_0000 + 32'(t), 32'hB000_0000 + 32'(t)};
        kptr    = {32'hC100_0000 + 32'(t), 32'hC000_0000 + 32'(t)};
        did     = {32'hE100_0000 + 32'(t), 32'hE000_0000 + 32'(t)};
        scr_off = 32'h0000_4000 + 32'(t);
        psize   = 32'd13 + 32'(t);
        wgid    = '{32'h300 + 32'(t), 32'h200 + 32'(t), 32'h100 + 32'(t)};
        first_wave = t[0];
        oa_term  = 11'h5A5 + 11'(t);
        wave_cnt = 6'h2B;
        wave_off = 32'h0008_0000 + 32'(t);
        for (int d = 0; d < 3; d++)
            for (int l = 0; l < LANES; l++) items[d][l] = 32'h1000_0000 * (d + 1) + 32'(t*16 + l);
    endtask

    // One full sequence; poke drives inputs and start mid-run (R1).
    task automatic run_case(input int t, input bit poke);
        int got_s, got_v, k;
        bit fin;
        set_inputs(t);
        build_expected();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        got_s = 0; got_v = 0; k = 0; fin = 1'b0;
        while (!fin && k < 80) begin
            @(negedge clk);
            k++;
            if (sgpr_we) begin
                chk(sgpr_idx == 5'(got_s), "R3 scalar index", 128'(sgpr_idx), 128'(got_s));
                chk(got_s < exp_ns && sgpr_data == exp_s[got_s], "R2/R4/R5/R7/R8/R9 scalar data",
                    128'(sgpr_data), 128'(exp_s[got_s]));
                got_s++;
            end
            if (vgpr_we) begin
                chk(got_s == exp_ns, "R10 vectors after scalars", 128'(got_s), 128'(exp_ns));
                chk(vgpr_idx == 2'(got_v) && vgpr_data == exp_v[got_v], "R10 vector write",
                    {vgpr_data}, exp_v[got_v]);
                got_v++;
            end
            if (k <= exp_ns + exp_nv)
                chk(busy == 1'b1, "R11 busy during run", 128'(busy), 128'(1));
            if (done) begin
                fin = 1'b1;
                chk(k == exp_ns + exp_nv + 1, "R11 done timing (R3 no gaps)", 128'(k),
                    128'(exp_ns + exp_nv + 1));
                chk(busy == 1'b0, "R11 busy low at done", 128'(busy), 128'(0));
            end
            if (poke && k == 2) begin
                start = 1'b1;
                grid[0] = grid[0] + 32'd1000;
                dptr = ~dptr;
                wgid[0] = 32'hDEAD;
            end
            if (poke && k == 3) start = 1'b0;
        end
        chk(fin, "R11 done seen", 128'(fin), 128'(1));
        chk(got_s == exp_ns, "R4 scalar count", 128'(got_s), 128'(exp_ns));
        chk(got_v == exp_nv, "R10 vector count", 128'(got_v), 128'(exp_nv));
        chk(user_cnt == 5'(exp_ucnt), "R4 user count", 128'(user_cnt), 128'(exp_ucnt));
        chk(err == exp_err, "R6 error flag", 128'(err), 128'(exp_err));
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk(!sgpr_we && !vgpr_we && !busy, "R1 ignored start leaves block idle",
                128'({sgpr_we, vgpr_we, busy}), 128'(0));
        end
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog R11 actual=timeout expected=finish");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        chk({sgpr_we, vgpr_we, busy, done, err} == 5'b0, "R12 reset outputs",
            128'({sgpr_we, vgpr_we, busy, done, err}), 128'(0));
        chk(user_cnt == 5'd0, "R12 reset user count", 128'(user_cnt), 128'(0));
        @(negedge clk); rst_n = 1'b1;
        for (int t = 0; t < NVEC; t++) run_case(t, t == 2);
        // Directed: zero divisor gives all ones in the count word (R6, R5).
        set_inputs(4);
        user_en = 10'h080; sys_en = '0; vmode = 2'd0;
        wgsz[0] = 32'd0; grid[0] = 32'd77;
        run_case_keep();
        // Directed: large extents, no overflow in ceiling (R5).
        set_inputs(3);
        user_en = 10'h200; sys_en = '0; vmode = 2'd0;
        grid[2] = 32'hFFFF_FFFF; wgsz[2] = 32'd2;
        run_case_keep();
        // Directed: rounding already aligned and flat scratch pair (R7).
        set_inputs(5);
        user_en = 10'h060; psize = 32'd64;
        run_case_keep();
        summary();
    end

    // Runs with the inputs already on the bench signals.
    task automatic run_case_keep();
        int got_s, k;
        bit fin;
        build_expected();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        got_s = 0; k = 0; fin = 1'b0;
        while (!fin && k < 80) begin
            @(negedge clk);
            k++;
            if (sgpr_we) begin
                chk(got_s < exp_ns && sgpr_data == exp_s[got_s], "R5/R6/R7 directed scalar data",
                    128'(sgpr_data), 128'(exp_s[got_s]));
                got_s++;
            end
            if (done) fin = 1'b1;
        end
        chk(fin && got_s == exp_ns, "R3 directed scalar count", 128'(got_s), 128'(exp_ns));
        chk(err == exp_err, "R6 directed error flag", 128'(err), 128'(exp_err));
    endtask
endmodule